// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address and control front end of a pipelined synchronous burst SRAM. On each rising clock edge it samples an external word address, two active-low address-status strobes, three chip enables, a burst-advance input and an ordering-mode input. When either strobe starts a load, the address is captured and a four-word burst begins at that address. Later advance requests step a two-bit offset through the burst, and the memory array downstream reads or writes one word per step.

The strobe on the processor side counts only when the primary chip enable is low. The strobe on the controller side always counts. A load also records whether all three enables selected the device. That flag is registered, so a device that is not selected leaves the shared bus within one cycle. The ordering-mode input is captured together with the address. It sets whether the two low address bits follow an interleaved (XOR) or a linear (add, wrapping) sequence. The upper address bits stay fixed for the whole burst.

Top module: `burst_addr_seq`

## Requirements
- R1: All inputs are sampled on the rising clock edge. The cycle after a load, `word_addr` equals the address presented at that load.
- R2: A load occurs when `ctl_strobe_n` is 0, whatever the chip enables are. It also occurs when `cpu_strobe_n` and `ce_main_n` are both 0.
- R3: When `cpu_strobe_n` is 0, `ce_main_n` is 1 and `ctl_strobe_n` is 1, nothing is loaded and nothing advances. `word_addr` and `sel_valid` keep their values, and `load_evt` and `step_evt` are 0 the next cycle.
- R4: After a load, `sel_valid` is 1 only if `ce_main_n`=0, `ce_aux_n`=0 and `ce_aux`=1 at that edge, and 0 otherwise. It changes only on loads, so a deselect takes effect in the next cycle.
- R5: The burst count advances by one only at an edge where `adv_n`=0 and both strobe pins are 1. At all other non-load edges it holds.
- R6: If `linear_mode` was 0 at the load, `word_addr[1:0]` = start[1:0] XOR count.
- R7: If `linear_mode` was 1 at the load, `word_addr[1:0]` = (start[1:0] + count) mod 4.
- R8: The count wraps from 3 to 0. The burst stays inside its four-word block, and `word_addr[ADDR_W-1:2]` never changes between loads.
- R9: A load replaces any burst in progress and sets the count back to 0. When both strobes are valid at the same edge, exactly one load takes place, from the same address.
- R10: `load_evt` is 1 for one cycle after each load edge. `step_evt` is 1 for one cycle after each advance edge.
- R11: While `rst_n` is 0, `word_addr`, `sel_valid`, `load_evt` and `step_evt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External word address |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, gated by ce_main_n |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| ce_main_n | input | 1 | Primary chip enable, active low |
| ce_aux_n | input | 1 | Expansion chip enable, active low |
| ce_aux | input | 1 | Expansion chip enable, active high |
| adv_n | input | 1 | Burst advance, active low |
| linear_mode | input | 1 | 1 = linear order, 0 = interleaved order (captured at load) |
| word_addr | output | ADDR_W | Current word address for the array |
| sel_valid | output | 1 | Device selected for the current burst |
| load_evt | output | 1 | The previous edge loaded a new address |
| step_evt | output | 1 | The previous edge advanced the burst |

## Verification
Complete four-word bursts run from every start offset in both orders. Where the two sequences differ, the result shows whether the XOR or the add rule was applied, and the fifth step shows that the burst wraps without carrying into the upper bits. A processor strobe presented with the primary enable high is compared against a controller strobe under the same enables. This separates correct strobe gating from a design that loads on any strobe. Further sequences cover the rest:
- each enable driven wrong on its own, to check the selection decode;
- a load in the middle of a burst;
- both strobes valid at the same edge;
- an advance request held together with a strobe, to check that the strobe blocks the advance.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int unsigned BURST_BITS = 2;

  typedef logic [BURST_BITS-1:0] offs_t;

  // Low address bits for a given start and burst count
  function automatic offs_t burst_offset(input offs_t start, input offs_t cnt,
                                         input logic lin);
    burst_offset = lin ? offs_t'(start + cnt) : (start ^ cnt);
  endfunction
endpackage

// File: rtl/bsq_strobe_decode.sv
module bsq_strobe_decode (
  input  logic cpu_strobe_n,
  input  logic ctl_strobe_n,
  input  logic ce_main_n,
  input  logic ce_aux_n,
  input  logic ce_aux,
  input  logic adv_n,
  output logic load_req,
  output logic step_req,
  output logic selected
);
  logic cpu_load;
  logic ctl_load;

  always_comb begin
    // processor strobe qualified by the primary enable; it wins when valid
    cpu_load = ~cpu_strobe_n & ~ce_main_n;
    ctl_load = ~ctl_strobe_n & ~cpu_load;
    load_req = cpu_load | ctl_load;
    // any strobe pin low blocks an advance, even a gated one
    step_req = ~adv_n & cpu_strobe_n & ctl_strobe_n;
    selected = ~ce_main_n & ~ce_aux_n & ce_aux;
  end
endmodule

// File: rtl/bsq_burst_ctr.sv
module bsq_burst_ctr
  import bsq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_req,
  input  logic  step_req,
  input  offs_t start_in,
  input  logic  lin_in,
  output offs_t offset
);
  offs_t cnt_q, cnt_d;
  offs_t start_q, start_d;
  logic  lin_q, lin_d;
  logic  cnt_en;

  always_comb begin
    cnt_en  = load_req | step_req;
    cnt_d   = load_req ? '0 : offs_t'(cnt_q + 1'b1);
    start_d = load_req ? start_in : start_q;
    lin_d   = load_req ? lin_in : lin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= '0;
      lin_q   <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
      lin_q   <= lin_d;
    end
  end

  assign offset = burst_offset(start_q, cnt_q, lin_q);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              ce_main_n,
  input  logic              ce_aux_n,
  input  logic              ce_aux,
  input  logic              adv_n,
  input  logic              linear_mode,
  output logic [ADDR_W-1:0] word_addr,
  output logic              sel_valid,
  output logic              load_evt,
  output logic              step_evt
);
  localparam int unsigned HI_W = ADDR_W - BURST_BITS;

  logic            load_req, step_req, selected;
  logic [HI_W-1:0] upper_q, upper_d;
  logic            sel_q, sel_d;
  logic            load_q, step_q;
  offs_t           offset;

  bsq_strobe_decode u_decode (
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .ce_main_n    (ce_main_n),
    .ce_aux_n     (ce_aux_n),
    .ce_aux       (ce_aux),
    .adv_n        (adv_n),
    .load_req     (load_req),
    .step_req     (step_req),
    .selected     (selected)
  );

  bsq_burst_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_req (load_req),
    .step_req (step_req),
    .start_in (addr_in[BURST_BITS-1:0]),
    .lin_in   (linear_mode),
    .offset   (offset)
  );

  always_comb begin
    upper_d = addr_in[ADDR_W-1:BURST_BITS];
    sel_d   = selected;
  end

  // load-enabled state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      sel_q   <= 1'b0;
    end else if (load_req) begin
      upper_q <= upper_d;
      sel_q   <= sel_d;
    end
  end

  // event flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      step_q <= 1'b0;
    end else begin
      load_q <= load_req;
      step_q <= step_req & ~load_req;
    end
  end

  assign word_addr = {upper_q, offset};
  assign sel_valid = sel_q;
  assign load_evt  = load_q;
  assign step_evt  = step_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              cpu_strobe_n,
  input logic              ctl_strobe_n,
  input logic              ce_main_n,
  input logic              ce_aux_n,
  input logic              ce_aux,
  input logic              adv_n,
  input logic [ADDR_W-1:0] word_addr,
  input logic              sel_valid,
  input logic              load_evt,
  input logic              step_evt
);
  // R1 R2: a controller strobe always captures the address
  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_strobe_n |=> (word_addr == $past(addr_in)) && load_evt);

  // R3: a gated processor strobe leaves everything unchanged
  assert_gated_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && ce_main_n && ctl_strobe_n) |=>
      $stable(word_addr) && $stable(sel_valid) && !load_evt && !step_evt);

  // R4: any enable not asserted at a load deselects the next cycle
  assert_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && (ce_main_n || ce_aux_n || !ce_aux)) |=> !sel_valid);

  // R5: an advance always moves the low bits
  assert_step_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_n && cpu_strobe_n && ctl_strobe_n) |=>
      (word_addr[1:0] != $past(word_addr[1:0])) && step_evt);

  // R8: the upper bits hold between loads
  assert_upper_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n && ctl_strobe_n) |=>
      $stable(word_addr[ADDR_W-1:2]) && !load_evt);

  // R10: the two event flags are never set together
  assert_evt_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_evt && step_evt));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int unsigned AW = 18;

  typedef struct {
    logic [AW-1:0] addr;
    logic          sel;
    logic          ld;
    logic          st;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          cpu_strobe_n, ctl_strobe_n, ce_main_n, ce_aux_n, ce_aux;
  logic          adv_n, linear_mode;
  logic [AW-1:0] word_addr;
  logic          sel_valid, load_evt, step_evt;

  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];
  bit   done = 1'b0;

  // bench model state
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_lin, m_sel;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one edge worth of inputs and push the expected result
  task automatic step(input logic [AW-1:0] a, input logic cpn, input logic ctn,
                      input logic e0n, input logic e1n, input logic e2,
                      input logic avn, input logic lin, input string req);
    exp_t e;
    logic ld, st;
    @(negedge clk);
    addr_in = a; cpu_strobe_n = cpn; ctl_strobe_n = ctn; ce_main_n = e0n;
    ce_aux_n = e1n; ce_aux = e2; adv_n = avn; linear_mode = lin;
    ld = (!cpn && !e0n) || !ctn;
    st = !avn && cpn && ctn && !ld;
    if (ld) begin
      m_base = a; m_cnt = 2'd0; m_lin = lin; m_sel = !e0n && !e1n && e2;
    end else if (st) begin
      m_cnt = m_cnt + 2'd1;
    end
    e.addr = {m_base[AW-1:2],
              m_lin ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
    e.sel = m_sel; e.ld = ld; e.st = st; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input string req);
    step(addr_in, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, linear_mode, req);
  endtask

  task automatic adv(input string req);
    step(addr_in, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, linear_mode, req);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(word_addr == e.addr, e.req, "word_addr", word_addr, e.addr);
        check(sel_valid == e.sel, e.req, "sel_valid", AW'(sel_valid), AW'(e.sel));
        check({load_evt, step_evt} == {e.ld, e.st}, e.req, "evt",
              AW'({load_evt, step_evt}), AW'({e.ld, e.st}));
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    addr_in = '0; cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; ce_main_n = 1'b1;
    ce_aux_n = 1'b1; ce_aux = 1'b0; adv_n = 1'b1; linear_mode = 1'b0;
    m_base = '0; m_cnt = '0; m_lin = 1'b0; m_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check(word_addr == '0 && !sel_valid && !load_evt && !step_evt, "R11",
          "reset outputs", AW'({word_addr != '0, sel_valid, load_evt, step_evt}), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R6 R7 R8: full bursts from every start, both orders, with a wrap
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        step(AW'(18'h2A5C0 | s), 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'(lin),
             lin ? "R7 linear load" : "R6 interleave load");
        for (int k = 0; k < 5; k++) adv(lin ? "R7 R8 linear step" : "R6 R8 xor step");
      end
    end

    // R5: advance blocked while a strobe pin is low (gated strobe), then hold
    step(18'h13572, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R2 ctl load deselected");
    step(18'h3FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 gated cpu strobe");
    step(18'h3FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 R5 gated strobe blocks adv");
    idle("R5 hold no adv");
    adv("R5 step");

    // R4: each enable wrong on its own
    step(18'h01001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4 all enables on");
    step(18'h01002, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4 main off");
    step(18'h01003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4 reselect");
    step(18'h01004, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4 aux_n off");
    step(18'h01005, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 aux off via cpu");

    // R9: load mid-burst, and both strobes at once
    step(18'h20003, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9 start");
    adv("R9 step");
    adv("R9 step");
    step(18'h2FF01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 reload mid-burst");
    adv("R9 R10 step after reload");
    step(18'h15556, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9 both strobes");
    adv("R10 step flag");
    idle("R10 flags clear");
    idle("R10 flags clear");

    wait (sb.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule